// File: doc/BRIEF.md
# SD Data Line Error Checker

This block watches the data phase of an SD transfer on the DAT0 line and reports three kinds of fault as single-cycle pulses: a bad end bit, a bad CRC result and a timeout. It runs in the system clock domain. A clock-enable input marks each SD clock step, and DAT0 and the phase markers are sampled only on those steps. A transfer begins with a start strobe and a mode code: read, write or plain busy-wait. The block then follows the line through the phases that mode expects.

On a read, the block waits for the start bit of a data block and then for the block-end marker. At that marker it checks the end bit and the CRC match flag, which is computed upstream. On a write, it waits for the start bit of the CRC-status token inside the token window. It captures the three status bits and the end bit that follows them, and then follows the card's busy signal. In busy-wait mode, used after a response that carries busy, only the busy signal is followed.

Every waiting phase has its own programmable limit, counted in SD clock steps. Any error sends the checker back to idle, and it stays there until the next start strobe.

States: `ST_IDLE`, `ST_RD_WAIT` (waiting for the read start bit), `ST_RD_DATA` (inside a read block), `ST_WR_WAIT` (waiting for the token start bit), `ST_WR_TOK` (collecting the status bits), `ST_WR_END` (token end bit), `ST_WR_BUSY` (busy after the token), `ST_BSY_WAIT` (busy-wait mode).

Transitions:
- A start strobe, from any state, goes to `ST_RD_WAIT` for code 01, `ST_WR_WAIT` for code 10, `ST_BSY_WAIT` for code 11 and `ST_IDLE` for code 00.
- `ST_RD_WAIT` goes to `ST_RD_DATA` on a start bit, or to `ST_IDLE` on a timeout.
- `ST_RD_DATA` goes to `ST_IDLE` at the block-end marker.
- `ST_WR_WAIT` goes to `ST_WR_TOK` on a start bit inside the window, or to `ST_IDLE` on a timeout.
- `ST_WR_TOK` goes to `ST_WR_END` once the third status bit is in.
- `ST_WR_END` goes to `ST_WR_BUSY` if the token and end bit are clean, and to `ST_IDLE` otherwise.
- `ST_WR_BUSY` and `ST_BSY_WAIT` go to `ST_IDLE` when busy is released or on a timeout.

Top module: `sd_dat_err_chk`

## Requirements
- R1: After reset, all three error outputs are 0 and the checker is idle: SD clock steps and markers produce no error until a start strobe arrives.
- R2: A start strobe selects the phase with `xfer_mode` (01 read, 10 write, 11 busy-wait, 00 none) and restarts the checker from any state. On that cycle it takes priority over every other event, so no error is raised. Code 00 leaves the checker idle.
- R3: In a read, the first step with DAT0 = 0 is the start bit. At the step where `rd_blk_end` = 1, the sampled DAT0 value is the end bit, and a 0 there raises `err_end`.
- R4: At the read block end, `rd_crc_ok` = 0 raises `err_crc`. It may fire in the same cycle as `err_end`.
- R5: In read wait, if `rd_to_lim` steps pass without a start bit, `err_tout` is raised on the step that reaches the limit. A start bit on that same step wins, and no timeout is raised.
- R6: In write wait, a step with `tok_win` = 1 and DAT0 = 0 is the token start bit. A low DAT0 while `tok_win` = 0 is ignored. The next three steps give the status token, first bit in the MSB. Any token other than 3'b010 raises `err_crc`.
- R7: The step after the third status bit is the token end bit, and a 0 there raises `err_end`. It may fire together with `err_crc`.
- R8: In write wait, if `tok_to_lim` steps pass without a token start bit, `err_tout` is raised.
- R9: After a clean token and end bit, the checker follows `card_busy`. A step with `card_busy` = 0 ends the transfer with no error. If `busy_to_lim` steps pass with busy still high, `err_tout` is raised.
- R10: In busy-wait mode (code 11), `card_busy` is followed with the same release and `busy_to_lim` timeout rules as R9.
- R11: Each error is a pulse one clock cycle wide, present in the cycle after the deciding step. After any error the checker stays idle, and later steps raise nothing until a new start strobe.
- R12: Input changes on cycles where `sd_ce` = 0 have no effect: DAT0 is not sampled and the timeout counters do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_ce | input | 1 | One-cycle strobe marking an SD clock step |
| dat0 | input | 1 | Sampled DAT0 level |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_mode | input | 2 | Phase select: 00 none, 01 read, 10 write, 11 busy-wait |
| rd_blk_end | input | 1 | Marks the end-bit step of a read block |
| rd_crc_ok | input | 1 | CRC16 match flag for the read block, valid with `rd_blk_end` |
| tok_win | input | 1 | CRC-status token window |
| card_busy | input | 1 | Card holds the data line busy |
| rd_to_lim | input | CNT_W | Read data timeout, in SD steps |
| tok_to_lim | input | CNT_W | Token arrival timeout, in SD steps |
| busy_to_lim | input | CNT_W | Busy timeout, in SD steps |
| err_end | output | 1 | End-bit error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_tout | output | 1 | Timeout pulse |

## Verification
The hardest case to reach is the busy timeout after a write. It can only be reached through a complete, clean token sequence: a start bit inside the window, exactly three status bits equal to 010, and a high end bit. Only after that does the busy counter run. The bench drives that whole path step by step and then holds busy high for the limit. It also drives two edge cases on purpose: a start bit placed on the very step that reaches a timeout limit, and a start strobe that lands on a block-end step carrying bad bits. In both cases the bench confirms that no pulse appears.

// File: rtl/sd_dat_err_pkg.sv
package sd_dat_err_pkg;

    localparam int TOK_W = 3;
    localparam logic [TOK_W-1:0] TOK_GOOD = 3'b010;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'b00,
        MODE_READ  = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_BUSY  = 2'b11
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR_WAIT,
        ST_WR_TOK,
        ST_WR_END,
        ST_WR_BUSY,
        ST_BSY_WAIT
    } chk_state_e;

    typedef struct packed {
        logic end_bit;
        logic crc;
        logic tout;
    } err_vec_t;

endpackage

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] lim,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign expired = step && (cnt_inc >= {1'b0, lim});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_inc[CNT_W-1:0];
        end
    end

    // Without a step and without a restart, the count must hold.
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));

endmodule

// File: rtl/sd_tok_capture.sv
module sd_tok_capture
    import sd_dat_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [TOK_W-1:0] tok,
    output logic             last
);

    localparam int NB_W = $clog2(TOK_W + 1);

    logic [NB_W-1:0] nbits;

    assign last = shift && (nbits == NB_W'(TOK_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok   <= '0;
            nbits <= '0;
        end else if (clr) begin
            nbits <= '0;
        end else if (shift) begin
            tok   <= {tok[TOK_W-2:0], bit_in};
            nbits <= last ? '0 : nbits + NB_W'(1);
        end
    end

    assert_bit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nbits < NB_W'(TOK_W));

endmodule

// File: rtl/sd_dat_err_chk.sv
module sd_dat_err_chk
    import sd_dat_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_ce,
    input  logic             dat0,
    input  logic             xfer_start,
    input  logic [1:0]       xfer_mode,
    input  logic             rd_blk_end,
    input  logic             rd_crc_ok,
    input  logic             tok_win,
    input  logic             card_busy,
    input  logic [CNT_W-1:0] rd_to_lim,
    input  logic [CNT_W-1:0] tok_to_lim,
    input  logic [CNT_W-1:0] busy_to_lim,
    output logic             err_end,
    output logic             err_crc,
    output logic             err_tout
);

    chk_state_e       state, state_nxt;
    err_vec_t         err_nxt, err_q;
    logic             tmr_step, tmr_clr, tmr_exp;
    logic [CNT_W-1:0] lim_sel;
    logic             tok_shift, tok_clr, tok_last;
    logic [TOK_W-1:0] tok_val;
    xfer_mode_e       mode;

    assign mode = xfer_mode_e'(xfer_mode);

    sd_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .step    (tmr_step),
        .lim     (lim_sel),
        .expired (tmr_exp)
    );

    sd_tok_capture u_tok (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tok_clr),
        .shift  (tok_shift),
        .bit_in (dat0),
        .tok    (tok_val),
        .last   (tok_last)
    );

    // Next state and error decode
    always_comb begin
        state_nxt = state;
        err_nxt   = '0;
        tmr_step  = 1'b0;
        lim_sel   = rd_to_lim;
        tok_shift = 1'b0;
        if (xfer_start) begin
            unique case (mode)
                MODE_NONE:  state_nxt = ST_IDLE;
                MODE_READ:  state_nxt = ST_RD_WAIT;
                MODE_WRITE: state_nxt = ST_WR_WAIT;
                MODE_BUSY:  state_nxt = ST_BSY_WAIT;
            endcase
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_RD_WAIT: begin
                    lim_sel  = rd_to_lim;
                    tmr_step = sd_ce;
                    if (sd_ce && !dat0) begin
                        state_nxt = ST_RD_DATA;
                    end else if (tmr_exp) begin
                        err_nxt.tout = 1'b1;
                        state_nxt    = ST_IDLE;
                    end
                end
                ST_RD_DATA: begin
                    if (sd_ce && rd_blk_end) begin
                        err_nxt.end_bit = !dat0;
                        err_nxt.crc     = !rd_crc_ok;
                        state_nxt       = ST_IDLE;
                    end
                end
                ST_WR_WAIT: begin
                    lim_sel  = tok_to_lim;
                    tmr_step = sd_ce;
                    if (sd_ce && tok_win && !dat0) begin
                        state_nxt = ST_WR_TOK;
                    end else if (tmr_exp) begin
                        err_nxt.tout = 1'b1;
                        state_nxt    = ST_IDLE;
                    end
                end
                ST_WR_TOK: begin
                    tok_shift = sd_ce;
                    if (tok_last) begin
                        state_nxt = ST_WR_END;
                    end
                end
                ST_WR_END: begin
                    if (sd_ce) begin
                        err_nxt.end_bit = !dat0;
                        err_nxt.crc     = (tok_val != TOK_GOOD);
                        state_nxt       = (!dat0 || (tok_val != TOK_GOOD)) ? ST_IDLE : ST_WR_BUSY;
                    end
                end
                ST_WR_BUSY, ST_BSY_WAIT: begin
                    lim_sel  = busy_to_lim;
                    tmr_step = sd_ce;
                    if (sd_ce && !card_busy) begin
                        state_nxt = ST_IDLE;
                    end else if (tmr_exp) begin
                        err_nxt.tout = 1'b1;
                        state_nxt    = ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign tmr_clr = xfer_start || (state_nxt != state);
    assign tok_clr = xfer_start || (state != ST_WR_TOK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_nxt;
        end
    end

    assign err_end  = err_q.end_bit;
    assign err_crc  = err_q.crc;
    assign err_tout = err_q.tout;

    // Helper views used by the checks below
    logic in_wait, in_check, any_err;
    assign in_wait  = (state == ST_RD_WAIT) || (state == ST_WR_WAIT) ||
                      (state == ST_WR_BUSY) || (state == ST_BSY_WAIT);
    assign in_check = (state == ST_RD_DATA) || (state == ST_WR_END);
    assign any_err  = err_end || err_crc || err_tout;

    assert_tout_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_tout |-> ($past(in_wait) && $past(sd_ce)));

    assert_crc_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_crc |-> ($past(in_check) && $past(sd_ce)));

    assert_end_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_end |-> ($past(in_check) && $past(sd_ce) && !$past(dat0)));

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |-> (state == ST_IDLE));

    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> !any_err);

    assert_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !any_err);

    assert_no_step_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ce && !xfer_start) |=> $stable(state));

    assert_tok_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_END) |-> ($past(state) == ST_WR_TOK || $past(state) == ST_WR_END));

endmodule

// File: tb/sd_dat_err_chk_tb.sv
`timescale 1ns/1ps
module sd_dat_err_chk_tb;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd_ce = 1'b0, dat0 = 1'b1, xfer_start = 1'b0;
    logic [1:0] xfer_mode = 2'b00;
    logic rd_blk_end = 1'b0, rd_crc_ok = 1'b1, tok_win = 1'b0, card_busy = 1'b0;
    logic [CNT_W-1:0] rd_to_lim = 16'd5, tok_to_lim = 16'd4, busy_to_lim = 16'd3;
    logic err_end, err_crc, err_tout;

    int n_chk = 0, n_bad = 0;
    int m_end = 0, m_crc = 0, m_tout = 0;
    int b_end = 0, b_crc = 0, b_tout = 0;

    always #2.5 clk = ~clk;

    sd_dat_err_chk #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sd_ce(sd_ce), .dat0(dat0),
        .xfer_start(xfer_start), .xfer_mode(xfer_mode),
        .rd_blk_end(rd_blk_end), .rd_crc_ok(rd_crc_ok), .tok_win(tok_win),
        .card_busy(card_busy), .rd_to_lim(rd_to_lim), .tok_to_lim(tok_to_lim),
        .busy_to_lim(busy_to_lim), .err_end(err_end), .err_crc(err_crc),
        .err_tout(err_tout)
    );

    // Pulse monitor: counts high cycles, so a two-cycle pulse counts twice
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_end)  m_end  = m_end + 1;
            if (err_crc)  m_crc  = m_crc + 1;
            if (err_tout) m_tout = m_tout + 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drv(input logic ce, input logic d, input logic be, input logic ok,
                       input logic win, input logic bsy, input logic st, input logic [1:0] md);
        sd_ce = ce; dat0 = d; rd_blk_end = be; rd_crc_ok = ok;
        tok_win = win; card_busy = bsy; xfer_start = st; xfer_mode = md;
        @(posedge clk); #1;
        sd_ce = 1'b0; xfer_start = 1'b0; rd_blk_end = 1'b0;
    endtask

    task automatic settle();
        sd_ce = 1'b0; xfer_start = 1'b0; rd_blk_end = 1'b0;
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic snap();
        b_end = m_end; b_crc = m_crc; b_tout = m_tout;
    endtask

    task automatic expect_err(input string tag, input int e, input int c, input int t);
        settle();
        chk({tag, " end"},  m_end  - b_end,  e);
        chk({tag, " crc"},  m_crc  - b_crc,  c);
        chk({tag, " tout"}, m_tout - b_tout, t);
        snap();
    endtask

    task automatic start(input logic [1:0] md);
        drv(0, 1, 0, 1, 0, 0, 1, md);
    endtask

    task automatic ce_bit(input logic d);
        drv(1, d, 0, 1, 0, 0, 0, 2'b00);
    endtask

    // Write token sequence: start bit in window, three status bits, end bit
    task automatic token(input logic [2:0] t, input logic endb);
        drv(1, 0, 0, 1, 1, 0, 0, 2'b00);
        for (int i = 2; i >= 0; i--) drv(1, t[i], 0, 1, 1, 0, 0, 2'b00);
        drv(1, endb, 0, 1, 1, 0, 0, 2'b00);
    endtask

    task automatic t_reset();
        snap();
        chk("R1 reset err_end", int'(err_end), 0);
        chk("R1 reset err_crc", int'(err_crc), 0);
        chk("R1 reset err_tout", int'(err_tout), 0);
        for (int i = 0; i < 8; i++) drv(1, 0, 1, 0, 1, 1, 0, 2'b00);
        expect_err("R1 idle steps", 0, 0, 0);
    endtask

    task automatic t_read_good();
        snap();
        start(2'b01);
        ce_bit(1); ce_bit(1); ce_bit(0);
        ce_bit(1); ce_bit(0); ce_bit(1);
        drv(1, 1, 1, 1, 0, 0, 0, 2'b00);
        expect_err("R3 read clean", 0, 0, 0);
    endtask

    task automatic t_read_bad();
        snap();
        start(2'b01);
        ce_bit(0); ce_bit(1);
        drv(1, 0, 1, 0, 0, 0, 0, 2'b00);
        expect_err("R3 R4 read end+crc", 1, 1, 0);
        start(2'b01);
        ce_bit(0);
        drv(1, 1, 1, 0, 0, 0, 0, 2'b00);
        expect_err("R4 read crc only", 0, 1, 0);
    endtask

    task automatic t_read_tout();
        snap();
        start(2'b01);
        for (int i = 0; i < 4; i++) ce_bit(1);
        expect_err("R5 before limit", 0, 0, 0);
        ce_bit(1);
        expect_err("R5 at limit", 0, 0, 1);
        drv(1, 0, 1, 0, 0, 0, 0, 2'b00);
        ce_bit(0);
        drv(1, 0, 1, 0, 0, 0, 0, 2'b00);
        expect_err("R11 idle after error", 0, 0, 0);
        start(2'b01);
        for (int i = 0; i < 4; i++) ce_bit(1);
        ce_bit(0);
        expect_err("R5 start bit wins", 0, 0, 0);
        drv(1, 1, 1, 1, 0, 0, 0, 2'b00);
        expect_err("R5 block after late start", 0, 0, 0);
    endtask

    task automatic t_no_ce();
        snap();
        start(2'b01);
        for (int i = 0; i < 10; i++) drv(0, 0, 1, 0, 1, 1, 0, 2'b00);
        expect_err("R12 no step no timeout", 0, 0, 0);
        drv(1, 0, 1, 0, 0, 0, 0, 2'b00);
        expect_err("R12 still waiting", 0, 0, 0);
        drv(1, 1, 1, 1, 0, 0, 0, 2'b00);
        expect_err("R12 block ends clean", 0, 0, 0);
    endtask

    task automatic t_write_good();
        snap();
        start(2'b10);
        ce_bit(1);
        drv(1, 0, 0, 1, 0, 0, 0, 2'b00);
        token(3'b010, 1'b1);
        drv(1, 0, 0, 1, 0, 1, 0, 2'b00);
        drv(1, 0, 0, 1, 0, 1, 0, 2'b00);
        drv(1, 1, 0, 1, 0, 0, 0, 2'b00);
        expect_err("R6 R9 write clean", 0, 0, 0);
    endtask

    task automatic t_write_bad();
        snap();
        start(2'b10);
        token(3'b101, 1'b1);
        expect_err("R6 token 101", 0, 1, 0);
        start(2'b10);
        token(3'b010, 1'b0);
        expect_err("R7 end bit low", 1, 0, 0);
        start(2'b10);
        token(3'b011, 1'b0);
        expect_err("R7 R6 both", 1, 1, 0);
    endtask

    task automatic t_write_tout();
        snap();
        start(2'b10);
        for (int i = 0; i < 3; i++) drv(1, 0, 0, 1, 0, 0, 0, 2'b00);
        expect_err("R8 before limit", 0, 0, 0);
        drv(1, 0, 0, 1, 0, 0, 0, 2'b00);
        expect_err("R8 token timeout", 0, 0, 1);
        start(2'b10);
        token(3'b010, 1'b1);
        drv(1, 1, 0, 1, 0, 1, 0, 2'b00);
        drv(1, 1, 0, 1, 0, 1, 0, 2'b00);
        expect_err("R9 busy before limit", 0, 0, 0);
        drv(1, 1, 0, 1, 0, 1, 0, 2'b00);
        expect_err("R9 busy timeout", 0, 0, 1);
    endtask

    task automatic t_busy_mode();
        snap();
        start(2'b11);
        for (int i = 0; i < 3; i++) drv(1, 0, 0, 1, 0, 1, 0, 2'b00);
        expect_err("R10 busy-wait timeout", 0, 0, 1);
        start(2'b11);
        drv(1, 0, 0, 1, 0, 1, 0, 2'b00);
        drv(1, 1, 0, 1, 0, 0, 0, 2'b00);
        for (int i = 0; i < 4; i++) drv(1, 0, 0, 1, 0, 1, 0, 2'b00);
        expect_err("R10 busy released", 0, 0, 0);
    endtask

    task automatic t_restart();
        snap();
        start(2'b01);
        ce_bit(0); ce_bit(1);
        drv(1, 0, 1, 0, 0, 0, 1, 2'b10);
        expect_err("R2 start over block end", 0, 0, 0);
        token(3'b010, 1'b1);
        drv(1, 1, 0, 1, 0, 0, 0, 2'b00);
        expect_err("R2 write after restart", 0, 0, 0);
        start(2'b01);
        ce_bit(1);
        start(2'b00);
        for (int i = 0; i < 7; i++) ce_bit(1);
        drv(1, 0, 1, 0, 0, 0, 0, 2'b00);
        expect_err("R2 mode none idles", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_read_good();
        t_read_bad();
        t_read_tout();
        t_no_ce();
        t_write_good();
        t_write_bad();
        t_write_tout();
        t_busy_mode();
        t_restart();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule